// File: doc/BRIEF.md
# Erase Range Walker

This block turns one erase request, given as a byte start address and a byte length, into a series of single-block erase commands for a downstream block-erase engine. It first checks the request against a table of erase regions, then walks it block by block. Each region has its own block size. The walk crosses region boundaries and chip boundaries as it goes. The region table is a set of packed 32-bit descriptors. These are supplied on a configuration bus that is held steady while the block is in use. The descriptors describe the regions of one chip, and every chip in the array has the same layout.

The request port uses valid/ready. `req_ready` is high only while the walker is idle, and a request is taken in the cycle where both signals are high. The block port also uses valid/ready. `blk_valid` stays high with its fields held steady until the engine raises `blk_ready`. Back-pressure on the block port stalls the walker. After each accepted block, the walker waits for the engine to pulse `eng_done` or `eng_fail` before it offers anything more. Completion, rejection and abort are each reported by a one-cycle pulse.

Top module: `erw_walker`

## Requirements
- R1: Each descriptor is 32 bits, and region i sits in bits [32i+31:32i] of `cfg_desc`. The block size in bytes is bits [31:16] times 256. The block count is bits [15:0] plus one. Regions are placed back to back from local offset 0 in every chip, and chip j starts at j * 2^CS.
- R2: A request is rejected if its start exceeds the total size (NCHIP * 2^CS), if start plus length exceeds the total size, or if the length is zero. A rejected request gives a one-cycle `walk_reject` pulse in the cycle after it is accepted, and no block is issued.
- R3: The start region is the last region whose offset is no greater than the local start address. The start address must be a multiple of that region's block size, otherwise the request is rejected.
- R4: The end address (start plus length) must be a multiple of the block size of the region that contains it, otherwise the request is rejected. That region is found by the same rule as in R3. An end equal to the total size belongs to the last region of the last chip.
- R5: Blocks are issued in rising address order. After each block, the address advances and the remaining length shrinks by the current region's block size. When the local address reaches the end of the current region, the walk moves on to the next region.
- R6: `blk_chip` is the address shifted right by CS, and `blk_addr` is the low CS bits. When a step crosses a chip boundary, the chip index rises by one and the walk restarts at region 0 and local address 0.
- R7: Whole-chip mode applies when the first region (after any reordering) has one block whose size equals 2^CS. In this mode only start 0 with a length equal to the total size is accepted. One command per chip is then issued, with `blk_whole` high and `blk_addr` 0.
- R8: When `cfg_flip` is high, the descriptor order is reversed before use.
- R9: `blk_valid` holds its fields steady until `blk_ready` is seen. After an accepted block, `blk_valid` stays low until the engine reports completion.
- R10: If `eng_fail` is raised, the walk stops. `walk_error` pulses once, no further block is issued, and `walk_done` does not pulse.
- R11: `walk_done` pulses for exactly one cycle, in the cycle after `eng_done` for the final block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_desc | input | NR*32 | Packed region descriptors, region 0 in the low word |
| cfg_flip | input | 1 | Reverse the descriptor order |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_start | input | AW | Request start byte address |
| req_len | input | AW | Request length in bytes |
| blk_valid | output | 1 | Block erase command offered |
| blk_ready | input | 1 | Engine takes the command |
| blk_chip | output | CW | Chip index of the block |
| blk_addr | output | CS | Byte address of the block within its chip |
| blk_whole | output | 1 | Command is a whole-chip erase |
| eng_done | input | 1 | Engine finished the last block (pulse) |
| eng_fail | input | 1 | Engine failed the last block (pulse) |
| walk_done | output | 1 | Whole request finished (pulse) |
| walk_reject | output | 1 | Request rejected (pulse) |
| walk_error | output | 1 | Walk aborted on an engine failure (pulse) |

## Verification
The bench builds the block with AW=16, two regions, two chips and CS=12. The main descriptors are a region of eight 256-byte blocks followed by a region of two 1 KiB blocks. This layout fills each 4 KiB chip exactly, so short requests can reach a region switch, a region wrap at a chip rollover, and an end that lands exactly on the total size. Reloading the descriptors brings two more cases within reach. Swapping the words with the flip input either set or cleared exercises the reordering. A single 4 KiB block in region 0 selects whole-chip mode.

// File: rtl/erw_pkg.sv
package erw_pkg;
  localparam int DESC_W = 32;
  localparam int BSZ_W  = 24;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2
  } walk_st_t;

  function automatic logic [BSZ_W-1:0] desc_bsize(input logic [DESC_W-1:0] d);
    return {d[31:16], 8'h00};
  endfunction

  function automatic logic [16:0] desc_count(input logic [DESC_W-1:0] d);
    return {1'b0, d[15:0]} + 17'd1;
  endfunction
endpackage

// File: rtl/erw_region_map.sv
module erw_region_map #(
  parameter int NR = 2,
  parameter int CS = 12,
  parameter int SW = 44
) (
  input  logic [NR*32-1:0]             raw,
  input  logic                         flip,
  output logic [NR-1:0][23:0]          bsz,
  output logic [NR-1:0][SW-1:0]        off,
  output logic [NR-1:0][CS-1:0]        rend,
  output logic                         whole
);
  import erw_pkg::*;
  localparam logic [SW-1:0] CHIP_BYTES = SW'(1) << CS;

  logic [NR-1:0][SW-1:0] rsize;

  for (genvar i = 0; i < NR; i++) begin : g_reg
    logic [DESC_W-1:0] d;
    assign d        = flip ? raw[(NR-1-i)*DESC_W +: DESC_W] : raw[i*DESC_W +: DESC_W];
    assign bsz[i]   = desc_bsize(d);
    assign rsize[i] = SW'(desc_bsize(d)) * SW'(desc_count(d));
  end

  always_comb begin
    logic [SW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NR; i++) begin
      off[i]  = acc;
      acc     = acc + rsize[i];
      rend[i] = acc[CS-1:0];
    end
  end

  assign whole = (rsize[0] == CHIP_BYTES) && (SW'(bsz[0]) == CHIP_BYTES);
endmodule

// File: rtl/erw_locate.sv
module erw_locate #(
  parameter int NR = 2,
  parameter int CS = 12,
  parameter int SW = 44,
  parameter int IW = 1
) (
  input  logic [CS-1:0]         x,
  input  logic                  last_sel,
  input  logic [NR-1:0][SW-1:0] off,
  output logic [IW-1:0]         idx
);
  always_comb begin
    idx = '0;
    for (int i = 1; i < NR; i++)
      if (off[i] <= SW'(x)) idx = IW'(i);
    if (last_sel) idx = IW'(NR-1);
  end
endmodule

// File: rtl/erw_walker.sv
module erw_walker #(
  parameter int AW    = 16,
  parameter int NR    = 2,
  parameter int NCHIP = 2,
  parameter int CS    = 12,
  localparam int CW   = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NR*32-1:0] cfg_desc,
  input  logic             cfg_flip,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_start,
  input  logic [AW-1:0]    req_len,
  output logic             blk_valid,
  input  logic             blk_ready,
  output logic [CW-1:0]    blk_chip,
  output logic [CS-1:0]    blk_addr,
  output logic             blk_whole,
  input  logic             eng_done,
  input  logic             eng_fail,
  output logic             walk_done,
  output logic             walk_reject,
  output logic             walk_error
);
  import erw_pkg::*;
  localparam int IW = (NR > 1) ? $clog2(NR) : 1;
  localparam int SW = 42 + $clog2(NR + 1);
  localparam logic [AW:0] TOTAL = (AW+1)'(NCHIP) << CS;

  logic [NR-1:0][23:0]   bsz;
  logic [NR-1:0][SW-1:0] off;
  logic [NR-1:0][CS-1:0] rend;
  logic                  whole;

  erw_region_map #(.NR(NR), .CS(CS), .SW(SW)) u_map (
    .raw(cfg_desc), .flip(cfg_flip), .bsz(bsz), .off(off), .rend(rend), .whole(whole)
  );

  logic [AW:0]   endv;
  logic          e_last;
  logic [IW-1:0] s_idx, e_idx;

  assign endv   = {1'b0, req_start} + {1'b0, req_len};
  assign e_last = (endv == TOTAL);

  erw_locate #(.NR(NR), .CS(CS), .SW(SW), .IW(IW)) u_loc_s (
    .x(req_start[CS-1:0]), .last_sel(1'b0), .off(off), .idx(s_idx)
  );
  erw_locate #(.NR(NR), .CS(CS), .SW(SW), .IW(IW)) u_loc_e (
    .x(endv[CS-1:0]), .last_sel(e_last), .off(off), .idx(e_idx)
  );

  // request screening
  logic [AW:0] m_s, m_e;
  logic        mis_s, mis_e, bad;
  always_comb begin
    m_s   = (AW+1)'(bsz[s_idx] - 24'd1);
    m_e   = (AW+1)'(bsz[e_idx] - 24'd1);
    mis_s = (({1'b0, req_start}) & m_s) != '0;
    mis_e = (endv & m_e) != '0;
    bad   = (req_len == '0) || ({1'b0, req_start} > TOTAL) || (endv > TOTAL);
    if (whole) bad = bad || (req_start != '0) || !e_last;
    else       bad = bad || mis_s || mis_e;
  end

  // walk state
  walk_st_t      st;
  logic [AW-1:0] cur;
  logic [AW:0]   rem, step, nxt;
  logic [IW-1:0] ridx;
  logic          w_q;

  assign step = (AW+1)'(bsz[ridx]);
  assign nxt  = {1'b0, cur} + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= W_IDLE;
      cur         <= '0;
      rem         <= '0;
      ridx        <= '0;
      w_q         <= 1'b0;
      walk_done   <= 1'b0;
      walk_reject <= 1'b0;
      walk_error  <= 1'b0;
    end else begin
      walk_done   <= 1'b0;
      walk_reject <= 1'b0;
      walk_error  <= 1'b0;
      case (st)
        W_IDLE: if (req_valid) begin
          if (bad) walk_reject <= 1'b1;
          else begin
            st   <= W_ISSUE;
            cur  <= req_start;
            rem  <= {1'b0, req_len};
            ridx <= whole ? '0 : s_idx;
            w_q  <= whole;
          end
        end
        W_ISSUE: if (blk_ready) st <= W_WAIT;
        W_WAIT: begin
          if (eng_fail) begin
            walk_error <= 1'b1;
            st         <= W_IDLE;
          end else if (eng_done) begin
            if (rem <= step || nxt >= TOTAL) begin
              walk_done <= 1'b1;
              st        <= W_IDLE;
            end else begin
              cur <= nxt[AW-1:0];
              rem <= rem - step;
              if (!w_q && nxt[CS-1:0] == rend[ridx])
                ridx <= (ridx == IW'(NR-1)) ? '0 : ridx + 1'b1;
              st <= W_ISSUE;
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign req_ready = (st == W_IDLE);
  assign blk_valid = (st == W_ISSUE);
  assign blk_chip  = CW'(cur >> CS);
  assign blk_addr  = cur[CS-1:0];
  assign blk_whole = w_q;

  AST_HOLD_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !blk_ready |=> blk_valid && $stable(blk_addr) && $stable(blk_chip)); // R9
  AST_WAIT_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_ready |=> !blk_valid); // R9
  AST_REJ_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    walk_reject |-> $past(req_valid && req_ready)); // R2
  AST_CHIP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> {1'b0, blk_chip} < (CW+1)'(NCHIP)); // R6
  AST_WHOLE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && blk_whole |-> blk_addr == '0); // R7
  AST_NO_BLK_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    walk_error |-> !blk_valid && !walk_done); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done); // R11
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({walk_done, walk_reject, walk_error})); // R11
endmodule

// File: tb/sim_erw_walker.sv
`timescale 1ns/1ps
module sim_erw_walker;
  localparam int AW = 16, NR = 2, NCHIP = 2, CS = 12, CW = 1;
  localparam logic [31:0] DESC_A = 32'h0001_0007; // 256 B x 8
  localparam logic [31:0] DESC_B = 32'h0004_0001; // 1024 B x 2
  localparam logic [31:0] DESC_W = 32'h0010_0000; // 4096 B x 1

  logic clk = 0, rst_n = 0;
  logic [NR*32-1:0] cfg_desc;
  logic cfg_flip = 0, req_valid = 0, blk_ready = 0, eng_done = 0, eng_fail = 0;
  logic [AW-1:0] req_start = 0, req_len = 0;
  logic req_ready, blk_valid, blk_whole, walk_done, walk_reject, walk_error;
  logic [CW-1:0] blk_chip;
  logic [CS-1:0] blk_addr;

  always #10 clk = ~clk;

  erw_walker #(.AW(AW), .NR(NR), .NCHIP(NCHIP), .CS(CS)) u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // results of one run
  int r_rej, r_done, r_err, r_cnt, r_whole, fc, fa, lc, la;
  bit r_late, r_hold_bad, r_wait_bad, r_after;

  task automatic run(input int st, input int ln, input int fail_at);
    int c, a;
    r_rej = 0; r_done = 0; r_err = 0; r_cnt = 0; r_whole = 0;
    fc = -1; fa = -1; lc = -1; la = -1;
    r_late = 0; r_hold_bad = 0; r_wait_bad = 0; r_after = 0;
    @(negedge clk); req_start = AW'(st); req_len = AW'(ln); req_valid = 1;
    @(negedge clk); req_valid = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (walk_reject) begin r_rej = 1; r_late = (cyc != 0); break; end
      if (walk_done)   begin r_done = 1; break; end
      if (walk_error)  begin r_err = 1; break; end
      if (blk_valid) begin
        c = int'(blk_chip); a = int'(blk_addr);
        if (r_cnt == 0) begin fc = c; fa = a; end
        lc = c; la = a;
        if (blk_whole) r_whole++;
        r_cnt++;
        @(negedge clk);
        if (!blk_valid || int'(blk_chip) != c || int'(blk_addr) != a) r_hold_bad = 1;
        blk_ready = 1;
        @(negedge clk); blk_ready = 0;
        if (blk_valid) r_wait_bad = 1;
        @(negedge clk);
        if (blk_valid) r_wait_bad = 1;
        if (r_cnt == fail_at) eng_fail = 1; else eng_done = 1;
        @(negedge clk); eng_fail = 0; eng_done = 0;
      end else @(negedge clk);
    end
    @(negedge clk);
    r_after = walk_done | walk_reject | walk_error | blk_valid;
  endtask

  // start, length, reject, count, first chip/addr, last chip/addr
  localparam int NV = 12;
  localparam int V_S[NV]  = '{0,   1792, 3072, 0,    128, 2048, 4096, 8448, 0, 7168, 2304, 4352};
  localparam int V_L[NV]  = '{256, 1280, 1280, 8192, 256, 512,  4097, 256,  0, 1024, 256,  1792};
  localparam int V_R[NV]  = '{0,   0,    0,    0,    1,   1,    1,    1,    1, 0,    1,    0};
  localparam int V_N[NV]  = '{1,   2,    2,    20,   0,   0,    0,    0,    0, 1,    0,    7};
  localparam int V_FC[NV] = '{0,   0,    0,    0,    0,   0,    0,    0,    0, 1,    0,    1};
  localparam int V_FA[NV] = '{0,   1792, 3072, 0,    0,   0,    0,    0,    0, 3072, 0,    256};
  localparam int V_LC[NV] = '{0,   0,    1,    1,    0,   0,    0,    0,    0, 1,    0,    1};
  localparam int V_LA[NV] = '{0,   2048, 0,    3072, 0,   0,    0,    0,    0, 3072, 0,    1792};
  // rows: R5 single, R1/R5 region switch, R6 rollover, R6 full range, R3 misaligned start,
  // R4 misaligned end, R2 end overflow, R2 start beyond, R2 zero length, R4 end at total,
  // R3 start in larger-block region, R5 run of small blocks

  initial begin
    cfg_desc = {DESC_B, DESC_A};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && blk_valid == 0, "R9 reset idle", {req_ready, blk_valid}, 2);
    chk({walk_done, walk_reject, walk_error} == 0, "R11 reset flags", {walk_done, walk_reject, walk_error}, 0);

    for (int v = 0; v < NV; v++) begin
      run(V_S[v], V_L[v], -1);
      if (V_R[v] != 0) begin
        chk(r_rej == 1 && !r_late, $sformatf("R2/R3/R4 vec%0d reject", v), r_rej, 1);
        chk(r_cnt == 0, $sformatf("R2 vec%0d no blocks", v), r_cnt, 0);
      end else begin
        chk(r_done == 1 && r_rej == 0, $sformatf("R11 vec%0d done", v), r_done, 1);
        chk(r_cnt == V_N[v], $sformatf("R5 vec%0d count", v), r_cnt, V_N[v]);
        chk(fc == V_FC[v] && fa == V_FA[v], $sformatf("R1 vec%0d first", v), fc*65536+fa, V_FC[v]*65536+V_FA[v]);
        chk(lc == V_LC[v] && la == V_LA[v], $sformatf("R6 vec%0d last", v), lc*65536+la, V_LC[v]*65536+V_LA[v]);
        chk(!r_hold_bad && !r_wait_bad, $sformatf("R9 vec%0d handshake", v), {r_hold_bad, r_wait_bad}, 0);
        chk(r_whole == 0, $sformatf("R7 vec%0d not whole", v), r_whole, 0);
      end
      chk(!r_after, $sformatf("R11 vec%0d single pulse", v), r_after, 0);
    end

    // R8: swapped words, flip restores order
    cfg_desc = {DESC_A, DESC_B}; cfg_flip = 1;
    run(1792, 1280, -1);
    chk(r_done == 1 && r_cnt == 2 && la == 2048, "R8 flip restores", r_cnt*65536+la, 2*65536+2048);
    cfg_flip = 0;
    run(1792, 1280, -1);
    chk(r_rej == 1, "R8 no flip misaligned", r_rej, 1);

    // R10: failure on the second of four blocks
    cfg_desc = {DESC_B, DESC_A};
    run(0, 1024, 2);
    chk(r_err == 1 && r_done == 0, "R10 error pulse", r_err*2+r_done, 2);
    chk(r_cnt == 2, "R10 stop after fail", r_cnt, 2);
    chk(!r_after, "R10 quiet after abort", r_after, 0);

    // R7: whole-chip mode
    cfg_desc = {DESC_A, DESC_W};
    run(0, 8192, -1);
    chk(r_done == 1 && r_cnt == 2 && r_whole == 2, "R7 whole per chip", r_cnt*16+r_whole, 2*16+2);
    chk(fc == 0 && fa == 0 && lc == 1 && la == 0, "R7 whole addresses", lc*65536+la, 65536);
    run(0, 4096, -1);
    chk(r_rej == 1 && r_cnt == 0, "R7 partial rejected", r_rej, 1);
    run(4096, 4096, -1);
    chk(r_rej == 1, "R7 nonzero start rejected", r_rej, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule